// File: doc/BRIEF.md
# Bridge Power-Management Configuration Register Slice

This block holds a small group of configuration-space registers for a PCI-to-PCI bridge. The group has three dwords. One holds a writable chassis number byte. One is a fixed power-management capability header that lists no optional power features. One is a control/status dword whose low two bits hold the bridge's current device power state. Only the fully-on and the off state are implemented by default. A write that names an intermediate state is accepted and then dropped. A write that moves the bridge from the off state back to fully-on makes the block emit a one-cycle internal soft-reset pulse. That pulse is kept apart from any secondary bus reset and clears the block's own writable state.

Access comes through a plain single-cycle configuration port. A write is one cycle with the write strobe high. A read is one cycle with the read strobe high, and the registered data comes back one cycle later, flagged by a read-valid pulse. The port never stalls. There is no ready signal and no back-pressure, so every strobe is taken in the cycle it is presented. The address is a byte address, and only its dword index (bits above bit 1) is decoded.

Top module: `pmcap_regs`

## Requirements
- R1: After reset the power state reads 00 (fully-on), the chassis byte reads 0x00, and `cfg_rvalid` and `soft_rst` are low.
- R2: A read strobe in cycle n gives `cfg_rvalid` high with the registered data in cycle n+1, and `cfg_rvalid` is low in every other cycle. A read issued in the same cycle as a write returns the value from before the write. Address bits 1:0 are ignored.
- R3: The capability dword at byte offset 0xDC always reads 0x0001B001: capability ID 0x01 in bits 7:0, next-item pointer 0xB0 in bits 15:8, version 3'b001 in bits 18:16, and zeros in bits 31:19, which include the intermediate-state support bits 25 and 26. Writes to it have no effect.
- R4: The control/status dword at 0xE0 reads the power state in bits 1:0 and zero in bits 31:2, including the wake-enable bit 8.
- R5: A write to 0xE0 with byte enable 0 set and data bits 1:0 equal to 00 or 11 loads that value into the power state.
- R6: A write to 0xE0 with data bits 1:0 equal to 01 or 10 completes but leaves the power state unchanged.
- R7: `soft_rst` is high for exactly one cycle, the cycle after a write that loads 00 while the state is 11. A write of 00 from state 00, a write of 11 from 11, or a dropped write produces no pulse.
- R8: The soft-reset pulse returns the chassis byte to 0x00 and the power state to 00.
- R9: The chassis byte is bits 31:24 of the dword at 0xB0. It is read/write, and bits 23:0 of that dword read as zero.
- R10: A byte lane whose enable is low is not written. With byte enable 3 low, the chassis byte is kept. With byte enable 0 low, the power state is kept and no pulse is produced.
- R11: Reads of any other dword return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 8 | Byte address of the access |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_rd | input | 1 | Read strobe, one cycle per read |
| cfg_rdata | output | 32 | Registered read data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| soft_rst | output | 1 | One-cycle internal soft-reset pulse |

## Verification
The assertions assume the inputs stay low while reset is held, so the first post-reset `$past` values are idle. They also assume every strobe is a whole cycle sampled at the rising edge, because the port has no handshake to stretch an access. The bench drives all inputs on the falling edge and clears the strobes after one cycle. After every write it adds an idle cycle, so a soft-reset pulse never overlaps a later access. The one exception is a directed same-cycle read and write, which checks the read-before-write ordering.

// File: rtl/pmcap_pkg.sv
package pmcap_pkg;

  typedef enum logic [1:0] {
    PWR_ON   = 2'b00,
    PWR_LOW1 = 2'b01,
    PWR_LOW2 = 2'b10,
    PWR_OFF  = 2'b11
  } pwr_state_e;

  typedef struct packed {
    logic chassis;
    logic cap;
    logic ctl;
  } reg_hit_t;

  localparam int DWORD_W = 32;

endpackage

// File: rtl/pmcap_decode.sv
module pmcap_decode
  import pmcap_pkg::*;
#(
  parameter int IDX_W       = 6,
  parameter int CHASSIS_OFS = 'hB0,
  parameter int CAP_OFS     = 'hDC,
  parameter int CTL_OFS     = 'hE0
) (
  input  logic [IDX_W-1:0] idx,
  output reg_hit_t         hit
);

  localparam logic [IDX_W-1:0] CHASSIS_IDX = IDX_W'(CHASSIS_OFS >> 2);
  localparam logic [IDX_W-1:0] CAP_IDX     = IDX_W'(CAP_OFS >> 2);
  localparam logic [IDX_W-1:0] CTL_IDX     = IDX_W'(CTL_OFS >> 2);

  always_comb begin
    hit         = '0;
    hit.chassis = (idx == CHASSIS_IDX);
    hit.cap     = (idx == CAP_IDX);
    hit.ctl     = (idx == CTL_IDX);
  end

endmodule

// File: rtl/pmcap_pstate.sv
module pmcap_pstate
  import pmcap_pkg::*;
#(
  parameter bit LOW1_OK = 1'b0,
  parameter bit LOW2_OK = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_val,
  output logic [1:0] state,
  output logic       pulse
);

  pwr_state_e cur_q;
  pwr_state_e req;
  logic       accept;
  logic       wake;
  logic       pulse_q;

  assign req = pwr_state_e'(wr_val);

  generate
    if (LOW1_OK && LOW2_OK) begin : g_all
      assign accept = 1'b1;
    end else if (LOW1_OK) begin : g_low1
      assign accept = (req != PWR_LOW2);
    end else if (LOW2_OK) begin : g_low2
      assign accept = (req != PWR_LOW1);
    end else begin : g_min
      assign accept = (req == PWR_ON) || (req == PWR_OFF);
    end
  endgenerate

  assign wake = wr_en && accept && (cur_q == PWR_OFF) && (req == PWR_ON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= PWR_ON;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= wake;
      if (pulse_q) begin
        cur_q <= PWR_ON;
      end else if (wr_en && accept) begin
        cur_q <= req;
      end
    end
  end

  assign state = cur_q;
  assign pulse = pulse_q;

endmodule

// File: rtl/pmcap_chassis.sv
module pmcap_chassis #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] value
);

  logic [W-1:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (clr) begin
      val_q <= '0;
    end else if (wr_en) begin
      val_q <= wr_val;
    end
  end

  assign value = val_q;

endmodule

// File: rtl/pmcap_regs.sv
module pmcap_regs
  import pmcap_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int CHASSIS_OFS = 'hB0,
  parameter int CAP_OFS     = 'hDC,
  parameter int CTL_OFS     = 'hE0,
  parameter int CAP_ID      = 'h01,
  parameter int CAP_VER     = 1,
  parameter bit LOW1_OK     = 1'b0,
  parameter bit LOW2_OK     = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  output logic [31:0]       cfg_rdata,
  output logic              cfg_rvalid,
  output logic              soft_rst
);

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [31:0] CAP_WORD =
      {5'd0, LOW2_OK, LOW1_OK, 6'd0, 3'(CAP_VER), 8'(CHASSIS_OFS), 8'(CAP_ID)};

  reg_hit_t    hit;
  logic [1:0]  pwr;
  logic [7:0]  chassis;
  logic        pulse;
  logic [31:0] rd_mux;
  logic [31:0] rdata_q;
  logic        rvalid_q;
  logic        unused_bits;

  assign unused_bits = ^{cfg_addr[1:0], cfg_be[2:1], cfg_wdata[23:2]};

  pmcap_decode #(
    .IDX_W      (IDX_W),
    .CHASSIS_OFS(CHASSIS_OFS),
    .CAP_OFS    (CAP_OFS),
    .CTL_OFS    (CTL_OFS)
  ) u_dec (
    .idx(cfg_addr[ADDR_W-1:2]),
    .hit(hit)
  );

  pmcap_pstate #(
    .LOW1_OK(LOW1_OK),
    .LOW2_OK(LOW2_OK)
  ) u_pst (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr && hit.ctl && cfg_be[0]),
    .wr_val(cfg_wdata[1:0]),
    .state (pwr),
    .pulse (pulse)
  );

  pmcap_chassis #(
    .W(8)
  ) u_chs (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (pulse),
    .wr_en (cfg_wr && hit.chassis && cfg_be[3]),
    .wr_val(cfg_wdata[31:24]),
    .value (chassis)
  );

  always_comb begin
    rd_mux = '0;
    if (hit.chassis) begin
      rd_mux[31:24] = chassis;
    end else if (hit.cap) begin
      rd_mux = CAP_WORD;
    end else if (hit.ctl) begin
      rd_mux[1:0] = pwr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= cfg_rd;
      rdata_q  <= cfg_rd ? rd_mux : '0;
    end
  end

  assign cfg_rdata  = rdata_q;
  assign cfg_rvalid = rvalid_q;
  assign soft_rst   = pulse;

endmodule

// File: rtl/pmcap_regs_chk.sv
module pmcap_regs_chk #(
  parameter int ADDR_W      = 8,
  parameter int CHASSIS_OFS = 'hB0,
  parameter int CAP_OFS     = 'hDC,
  parameter int CTL_OFS     = 'hE0,
  parameter int CAP_ID      = 'h01,
  parameter int CAP_VER     = 1,
  parameter bit LOW1_OK     = 1'b0,
  parameter bit LOW2_OK     = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              be0,
  input logic [1:0]        wlo,
  input logic              wr,
  input logic              rd,
  input logic [31:0]       rdata,
  input logic              rvalid,
  input logic              srst
);

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] I_CH  = IDX_W'(CHASSIS_OFS >> 2);
  localparam logic [IDX_W-1:0] I_CAP = IDX_W'(CAP_OFS >> 2);
  localparam logic [IDX_W-1:0] I_CTL = IDX_W'(CTL_OFS >> 2);
  localparam logic [31:0] EXP_CAP =
      {5'd0, LOW2_OK, LOW1_OK, 6'd0, 3'(CAP_VER), 8'(CHASSIS_OFS), 8'(CAP_ID)};

  logic [IDX_W-1:0] idx;
  logic             unused_lsb;
  assign idx        = addr[ADDR_W-1:2];
  assign unused_lsb = ^addr[1:0];

  assert_rvalid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid);
  assert_no_stray_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rvalid);
  assert_cap_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && idx == I_CAP) |=> (rdata == EXP_CAP));
  assert_ctl_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && idx == I_CTL) |=> (rdata[31:2] == 30'd0));
  assert_no_low_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && idx == I_CTL) |=> ((LOW1_OK || rdata[1:0] != 2'b01) &&
                              (LOW2_OK || rdata[1:0] != 2'b10)));
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !srst);
  assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    srst |-> $past(wr && idx == I_CTL && be0 && wlo == 2'b00));
  assert_chassis_low_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && idx == I_CH) |=> (rdata[23:0] == 24'd0));
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && idx != I_CH && idx != I_CAP && idx != I_CTL) |=> (rdata == 32'd0));

endmodule

bind pmcap_regs pmcap_regs_chk #(
  .ADDR_W     (ADDR_W),
  .CHASSIS_OFS(CHASSIS_OFS),
  .CAP_OFS    (CAP_OFS),
  .CTL_OFS    (CTL_OFS),
  .CAP_ID     (CAP_ID),
  .CAP_VER    (CAP_VER),
  .LOW1_OK    (LOW1_OK),
  .LOW2_OK    (LOW2_OK)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .addr  (cfg_addr),
  .be0   (cfg_be[0]),
  .wlo   (cfg_wdata[1:0]),
  .wr    (cfg_wr),
  .rd    (cfg_rd),
  .rdata (cfg_rdata),
  .rvalid(cfg_rvalid),
  .srst  (soft_rst)
);

// File: tb/sim_pmcap_regs.sv
`timescale 1ns/1ps
module sim_pmcap_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;
  logic        soft_rst;

  int checks = 0;
  int fails  = 0;
  logic [1:0] m_state = 2'b00;
  logic [7:0] m_chassis = 8'h00;

  always #5 clk = ~clk;

  pmcap_regs u0 (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid), .soft_rst(soft_rst)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a[7:2])
      6'h2C:   return {m_chassis, 24'd0};
      6'h37:   return 32'h0001B001;
      6'h38:   return {30'd0, m_state};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [7:0] a, input string req);
    logic [31:0] e;
    e = exp_read(a);
    cfg_addr = a; cfg_rd = 1'b1;
    @(negedge clk);
    cfg_rd = 1'b0;
    check({req, " rvalid"}, {31'd0, cfg_rvalid}, 32'd1);
    check(req, cfg_rdata, e);
    @(negedge clk);
    check("R2 rvalid low", {31'd0, cfg_rvalid}, 32'd0);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [3:0] be,
                          input logic [31:0] d, input string req);
    logic pulse;
    logic [1:0] nv;
    pulse = 1'b0;
    if (a[7:2] == 6'h38 && be[0]) begin
      nv = d[1:0];
      if (nv == 2'b00 || nv == 2'b11) begin
        pulse = (m_state == 2'b11) && (nv == 2'b00);
        m_state = nv;
      end
    end
    if (a[7:2] == 6'h2C && be[3]) m_chassis = d[31:24];
    cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    check({req, " R7 pulse"}, {31'd0, soft_rst}, {31'd0, pulse});
    if (pulse) m_chassis = 8'h00;
    @(negedge clk);
    check("R7 pulse width", {31'd0, soft_rst}, 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] pick[4];
    pick[0] = 8'hB0; pick[1] = 8'hDC; pick[2] = 8'hE0; pick[3] = 8'h00;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rvalid", {31'd0, cfg_rvalid}, 32'd0);
    check("R1 soft_rst", {31'd0, soft_rst}, 32'd0);
    do_read(8'hE0, "R1 state");
    do_read(8'hB0, "R1 chassis");
    do_read(8'hDC, "R3 cap");
    do_read(8'hDF, "R2 low bits ignored");
    do_write(8'hDC, 4'hF, 32'hFFFFFFFF, "R3 write");
    do_read(8'hDC, "R3 cap after write");
    do_write(8'hB0, 4'h8, 32'hA5FFFFFF, "R9 write");
    do_read(8'hB0, "R9 chassis");
    do_write(8'hB0, 4'h7, 32'h11FFFFFF, "R10 be3 low");
    do_read(8'hB0, "R10 chassis kept");
    do_write(8'hE0, 4'h1, 32'hFFFFFF01, "R6 low1");
    do_read(8'hE0, "R6 state kept");
    do_write(8'hE0, 4'h1, 32'h00000003, "R5 off");
    do_read(8'hE0, "R5 state off");
    do_write(8'hE0, 4'h1, 32'h00000002, "R6 low2");
    do_read(8'hE0, "R6 state kept off");
    do_write(8'hE0, 4'h1, 32'h00000003, "R7 off to off");
    do_write(8'hE0, 4'hE, 32'h00000000, "R10 be0 low");
    do_read(8'hE0, "R10 state kept");
    do_write(8'h40, 4'hF, 32'hFFFFFFFF, "R11 unmapped");
    do_read(8'h40, "R11 unmapped zero");
    do_read(8'hB0, "R11 chassis untouched");
    // R2: read and write in the same cycle returns the old value
    cfg_addr = 8'hB0; cfg_be = 4'h8; cfg_wdata = 32'h5A000000;
    cfg_wr = 1'b1; cfg_rd = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_rd = 1'b0;
    check("R2 read before write", cfg_rdata, {m_chassis, 24'd0});
    m_chassis = 8'h5A;
    @(negedge clk);
    do_read(8'hB0, "R2 write landed");
    do_write(8'hE0, 4'h1, 32'h00000000, "R7 wake");
    do_read(8'hB0, "R8 chassis cleared");
    do_read(8'hE0, "R8 state on");
    do_write(8'hE0, 4'h1, 32'h00000000, "R7 on to on");
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      a = pick[$urandom_range(0, 3)] | 8'($urandom_range(0, 3));
      if (a[7:2] == 6'h00) a = 8'($urandom);
      if ($urandom_range(0, 1) == 1)
        do_write(a, 4'($urandom), $urandom, "R5 random write");
      else
        do_read(a, "R4 random read");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule